// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. Two kinds of storage back the decision: sixteen exact-match slots, each holding one full address with its own valid flag, and a 4096-bit multicast table indexed by a 12-bit hash taken from a selectable window of address bits. An all-ones address is always taken as broadcast.

Configuration goes through a small command port. Each command carries an opcode, a word index and a 32-bit data word. Commands can write or read slot words, write or read table words, set a single table bit, or clear the whole table. A controller state machine with the states IDLE, SET_READ, SET_WRITE and CLEAR sequences the commands. IDLE accepts a command. A set-bit command moves IDLE to SET_READ, then SET_READ to SET_WRITE, then SET_WRITE back to IDLE. A clear command moves IDLE to CLEAR, and CLEAR returns to IDLE after the last table word. The command port is ready only in IDLE.

Lookups are independent of the command port. A destination address presented with a strobe yields a registered verdict one cycle later: accept or reject, together with which path produced the match.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every slot word and table word reads zero, `cmd_ready` is 1, and `res_valid`, `res_accept` and `res_path` are 0.
- R2: Slot n occupies word indices 2n (low) and 2n+1 (high). Address byte k sits at `lk_addr[8k+7:8k]`. The low word holds bytes 0..3 with byte 0 in bits 7:0. The high word holds bytes 4..5 in bits 15:0, and bit 31 of the high word is the slot's valid flag. An address that equals a valid slot's contents is accepted with path 1 (exact).
- R3: Rewriting a slot's high word with bit 31 clear stops that slot from matching, even though its low word is unchanged.
- R4: The 12-bit hash depends on `mc_mode`. Mode 0 uses `lk_addr[47:36]`, mode 1 uses `[46:35]`, mode 2 uses `[45:34]` and mode 3 uses `[43:32]`.
- R5: Hash value h selects table word h[11:5] and bit h[4:0] within that word. Command opcode 2 writes table word `cmd_idx`, and the write is visible to both reads and lookups.
- R6: Opcode 4 sets table bit `cmd_wdata[11:0]` by reading the word, ORing in the bit and writing it back. The other bits of the word are kept, and `cmd_ready` stays low for 2 cycles.
- R7: Opcode 5 zeroes all 128 table words, one per cycle, with `cmd_ready` low for 128 cycles. Slot contents are not affected.
- R8: The table is consulted only for group addresses (bit 0 of byte 0 set) that match no valid slot, giving path 2 (hash). An exact hit takes priority, and a unicast address never matches through the table.
- R9: The all-ones address is accepted with path 3 (broadcast) regardless of the slots and the table.
- R10: `res_valid` is high exactly in the cycle after `lk_valid`. On a reject, `res_accept` is 0 and `res_path` is 0.
- R11: Opcode 1 (slot read, index `cmd_idx[4:0]`) and opcode 3 (table read, index `cmd_idx`) return `rd_data` with `rd_valid` high exactly one cycle after the command is accepted. Opcode 0 writes slot word `cmd_idx[4:0]`.
- R12: A command presented while `cmd_ready` is low, or one carrying opcode 6 or 7, changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_op | input | 3 | Opcode: 0 slot write, 1 slot read, 2 table write, 3 table read, 4 set bit, 5 clear table |
| cmd_idx | input | 7 | Word index (slot ops use bits 4:0) |
| cmd_wdata | input | 32 | Write data; for set-bit, bits 11:0 are the hash |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| mc_mode | input | 2 | Hash window select |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Lookup verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_path | output | 2 | 0 none, 1 exact, 2 hash, 3 broadcast |

## Verification
The hardest case to reach from the ports is an address that is present both in a valid slot and in the multicast table, because priority only shows when both paths agree. The stimulus therefore sets the table bit that the slot's own address hashes to, and also sets that bit in a word that was written directly beforehand, so that the OR in the read-modify-write is visible. Commands are also driven into the cycles in which the controller is busy with a set-bit operation, and the targeted word is read back afterwards.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int ADDR_W = 48;
    localparam int HASH_W = 12;

    typedef enum logic [2:0] {
        OP_SLOT_WR = 3'd0,
        OP_SLOT_RD = 3'd1,
        OP_TBL_WR  = 3'd2,
        OP_TBL_RD  = 3'd3,
        OP_BIT_SET = 3'd4,
        OP_TBL_CLR = 3'd5
    } daf_op_e;

    typedef enum logic [1:0] {
        PATH_NONE  = 2'd0,
        PATH_EXACT = 2'd1,
        PATH_HASH  = 2'd2,
        PATH_BCAST = 2'd3
    } daf_path_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SET_READ  = 2'd1,
        ST_SET_WRITE = 2'd2,
        ST_CLEAR     = 2'd3
    } daf_state_e;

    // Pick the 12-bit window of the address selected by the mode.
    function automatic logic [HASH_W-1:0] hash_index(input logic [ADDR_W-1:0] a,
                                                     input logic [1:0] mode);
        logic [HASH_W-1:0] h;
        unique case (mode)
            2'd0: h = a[47:36];
            2'd1: h = a[46:35];
            2'd2: h = a[45:34];
            default: h = a[43:32];
        endcase
        return h;
    endfunction
endpackage

// File: rtl/daf_slot_bank.sv
module daf_slot_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(2*NUM_SLOTS)-1:0] wr_idx,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [$clog2(2*NUM_SLOTS)-1:0] rd_idx,
    output logic [WORD_W-1:0]         rd_word,
    input  logic [ADDR_W-1:0]         lk_addr,
    output logic [NUM_SLOTS-1:0]      hit_vec
);
    localparam int NWORDS    = 2 * NUM_SLOTS;
    localparam int WIDX_W    = $clog2(NWORDS);
    localparam int VALID_BIT = WORD_W - 1;
    localparam int HI_BITS   = ADDR_W - WORD_W;

    logic [WORD_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] lo_q;
        logic [WORD_W-1:0] hi_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en) begin
                if (wr_idx == WIDX_W'(2*g))
                    lo_q <= wr_data;
                if (wr_idx == WIDX_W'(2*g+1))
                    hi_q <= wr_data;
            end
        end

        assign words[2*g]   = lo_q;
        assign words[2*g+1] = hi_q;
        assign hit_vec[g]   = hi_q[VALID_BIT]
                            && (lo_q == lk_addr[WORD_W-1:0])
                            && (hi_q[HI_BITS-1:0] == lk_addr[ADDR_W-1:WORD_W]);
    end

    assign rd_word = words[rd_idx];
endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table #(
    parameter int TBL_BITS = 4096,
    parameter int WORD_W   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(TBL_BITS/WORD_W)-1:0] wr_idx,
    input  logic [WORD_W-1:0]                  wr_data,
    input  logic [$clog2(TBL_BITS/WORD_W)-1:0] rd_idx,
    output logic [WORD_W-1:0]                  rd_word,
    input  logic [$clog2(TBL_BITS)-1:0]        lk_hash,
    output logic                               lk_bit
);
    localparam int NWORDS = TBL_BITS / WORD_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int HASH_W = $clog2(TBL_BITS);

    logic [WORD_W-1:0] mem [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    logic [WORD_W-1:0] lk_word;

    assign rd_word = mem[rd_idx];
    assign lk_word = mem[lk_hash[HASH_W-1:BIT_W]];
    assign lk_bit  = lk_word[lk_hash[BIT_W-1:0]];
endmodule

// File: rtl/daf_ctrl_fsm.sv
module daf_ctrl_fsm
    import daf_pkg::*;
#(
    parameter int SLOT_IDX_W = 5,
    parameter int TBL_IDX_W  = 7,
    parameter int CMD_IDX_W  = 7,
    parameter int WORD_W     = 32,
    parameter int BIT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [CMD_IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0]     cmd_wdata,
    output logic                  cmd_ready,
    output logic                  slot_wr_en,
    output logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic [WORD_W-1:0]     slot_rd_word,
    output logic                  tbl_wr_en,
    output logic [TBL_IDX_W-1:0]  tbl_wr_idx,
    output logic [WORD_W-1:0]     tbl_wr_data,
    output logic [TBL_IDX_W-1:0]  tbl_rd_idx,
    input  logic [WORD_W-1:0]     tbl_rd_word,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int NWORDS = 1 << TBL_IDX_W;

    daf_state_e        state_q, state_d;
    logic [TBL_IDX_W-1:0] pend_widx_q;
    logic [BIT_W-1:0]     pend_bit_q;
    logic [WORD_W-1:0]    rmw_word_q;
    logic [TBL_IDX_W-1:0] clr_cnt_q;
    logic                 accept;
    logic                 is_rd;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign is_rd  = (cmd_op == OP_SLOT_RD) || (cmd_op == OP_TBL_RD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && cmd_op == OP_BIT_SET)      state_d = ST_SET_READ;
                else if (accept && cmd_op == OP_TBL_CLR) state_d = ST_CLEAR;
            end
            ST_SET_READ:  state_d = ST_SET_WRITE;
            ST_SET_WRITE: state_d = ST_IDLE;
            ST_CLEAR: begin
                if (clr_cnt_q == TBL_IDX_W'(NWORDS - 1)) state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs towards storage
    always_comb begin
        cmd_ready   = 1'b0;
        slot_wr_en  = 1'b0;
        slot_idx    = cmd_idx[SLOT_IDX_W-1:0];
        tbl_wr_en   = 1'b0;
        tbl_wr_idx  = cmd_idx[TBL_IDX_W-1:0];
        tbl_wr_data = cmd_wdata;
        tbl_rd_idx  = pend_widx_q;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready  = 1'b1;
                tbl_rd_idx = cmd_idx[TBL_IDX_W-1:0];
                slot_wr_en = accept && (cmd_op == OP_SLOT_WR);
                tbl_wr_en  = accept && (cmd_op == OP_TBL_WR);
            end
            ST_SET_READ: begin
                tbl_rd_idx = pend_widx_q;
            end
            ST_SET_WRITE: begin
                tbl_wr_en   = 1'b1;
                tbl_wr_idx  = pend_widx_q;
                tbl_wr_data = rmw_word_q | (WORD_W'(1) << pend_bit_q);
            end
            ST_CLEAR: begin
                tbl_wr_en   = 1'b1;
                tbl_wr_idx  = clr_cnt_q;
                tbl_wr_data = '0;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_widx_q <= '0;
            pend_bit_q  <= '0;
            rmw_word_q  <= '0;
            clr_cnt_q   <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            rd_valid <= accept && is_rd;
            if (accept && is_rd)
                rd_data <= (cmd_op == OP_SLOT_RD) ? slot_rd_word : tbl_rd_word;
            if (accept && cmd_op == OP_BIT_SET) begin
                pend_widx_q <= cmd_wdata[BIT_W+TBL_IDX_W-1:BIT_W];
                pend_bit_q  <= cmd_wdata[BIT_W-1:0];
            end
            if (state_q == ST_SET_READ)
                rmw_word_q <= tbl_rd_word;
            if (accept && cmd_op == OP_TBL_CLR)
                clr_cnt_q <= '0;
            else if (state_q == ST_CLEAR)
                clr_cnt_q <= clr_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int WORD_W    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [6:0]  cmd_idx,
    input  logic [31:0] cmd_wdata,
    output logic        cmd_ready,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic [1:0]  mc_mode,
    input  logic        lk_valid,
    input  logic [47:0] lk_addr,
    output logic        res_valid,
    output logic        res_accept,
    output logic [1:0]  res_path
);
    localparam int TBL_BITS   = 1 << HASH_W;
    localparam int TBL_WORDS  = TBL_BITS / WORD_W;
    localparam int TBL_IDX_W  = $clog2(TBL_WORDS);
    localparam int SLOT_IDX_W = $clog2(2 * NUM_SLOTS);
    localparam int BIT_W      = $clog2(WORD_W);

    logic                  slot_wr_en;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic [WORD_W-1:0]     slot_rd_word;
    logic                  tbl_wr_en;
    logic [TBL_IDX_W-1:0]  tbl_wr_idx;
    logic [WORD_W-1:0]     tbl_wr_data;
    logic [TBL_IDX_W-1:0]  tbl_rd_idx;
    logic [WORD_W-1:0]     tbl_rd_word;
    logic [NUM_SLOTS-1:0]  hit_vec;
    logic [HASH_W-1:0]     lk_hash;
    logic                  tbl_bit;

    daf_ctrl_fsm #(
        .SLOT_IDX_W(SLOT_IDX_W),
        .TBL_IDX_W (TBL_IDX_W),
        .CMD_IDX_W (7),
        .WORD_W    (WORD_W),
        .BIT_W     (BIT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_idx     (cmd_idx),
        .cmd_wdata   (cmd_wdata),
        .cmd_ready   (cmd_ready),
        .slot_wr_en  (slot_wr_en),
        .slot_idx    (slot_idx),
        .slot_rd_word(slot_rd_word),
        .tbl_wr_en   (tbl_wr_en),
        .tbl_wr_idx  (tbl_wr_idx),
        .tbl_wr_data (tbl_wr_data),
        .tbl_rd_idx  (tbl_rd_idx),
        .tbl_rd_word (tbl_rd_word),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    daf_slot_bank #(
        .NUM_SLOTS(NUM_SLOTS),
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W)
    ) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (slot_wr_en),
        .wr_idx (slot_idx),
        .wr_data(cmd_wdata),
        .rd_idx (slot_idx),
        .rd_word(slot_rd_word),
        .lk_addr(lk_addr),
        .hit_vec(hit_vec)
    );

    assign lk_hash = hash_index(lk_addr, mc_mode);

    daf_hash_table #(
        .TBL_BITS(TBL_BITS),
        .WORD_W  (WORD_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_data(tbl_wr_data),
        .rd_idx (tbl_rd_idx),
        .rd_word(tbl_rd_word),
        .lk_hash(lk_hash),
        .lk_bit (tbl_bit)
    );

    // Verdict: broadcast over exact over hash (group addresses only)
    logic      is_bcast, is_exact, is_hash;
    daf_path_e path_d;

    assign is_bcast = &lk_addr;
    assign is_exact = |hit_vec;
    assign is_hash  = lk_addr[0] && tbl_bit;

    always_comb begin
        if (is_bcast)      path_d = PATH_BCAST;
        else if (is_exact) path_d = PATH_EXACT;
        else if (is_hash)  path_d = PATH_HASH;
        else               path_d = PATH_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_path   <= PATH_NONE;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_accept <= is_bcast || is_exact || is_hash;
                res_path   <= path_d;
            end else begin
                res_accept <= 1'b0;
                res_path   <= PATH_NONE;
            end
        end
    end
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        cmd_ready,
    input logic        rd_valid,
    input logic        lk_valid,
    input logic [47:0] lk_addr,
    input logic        res_valid,
    input logic        res_accept,
    input logic [1:0]  res_path
);
    logic took, took_rd;
    assign took    = cmd_valid && cmd_ready;
    assign took_rd = took && (cmd_op == 3'd1 || cmd_op == 3'd3);

    AST_RES_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R10
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R10
    AST_BCAST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (&lk_addr)) |=> (res_accept && res_path == 2'd3)); // R9
    AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[0]) |=> (res_path != 2'd2)); // R8
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        took_rd |=> rd_valid); // R11
    AST_NO_UNASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !took_rd |=> !rd_valid); // R11
    AST_SET_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (took && cmd_op == 3'd4) |=> !cmd_ready ##1 !cmd_ready); // R6
    AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (took && cmd_op == 3'd5) |=> !cmd_ready); // R7
endmodule

bind dest_addr_filter daf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .res_valid (res_valid),
    .res_accept(res_accept),
    .res_path  (res_path)
);

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [6:0]  cmd_idx = '0;
    logic [31:0] cmd_wdata = '0;
    logic        cmd_ready;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  mc_mode = '0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid;
    logic        res_accept;
    logic [1:0]  res_path;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dest_addr_filter u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [6:0] idx, input logic [31:0] d);
        wait_ready();
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] op, input logic [6:0] idx, input string tag,
                      input logic [31:0] exp);
        wait_ready();
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " rd_valid"}, 64'(rd_valid), 64'd1);
        chk({tag, " rd_data"}, 64'(rd_data), 64'(exp));
    endtask

    task automatic look(input logic [47:0] a, input logic [1:0] m, input string tag,
                        input logic acc, input logic [1:0] p);
        lk_valid = 1'b1; lk_addr = a; mc_mode = m;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " res_valid"}, 64'(res_valid), 64'd1);
        chk({tag, " accept"}, 64'(res_accept), 64'(acc));
        chk({tag, " path"}, 64'(res_path), 64'(p));
    endtask

    // {address, mode, expected accept, expected path}
    localparam int NV = 13;
    localparam logic [52:0] VEC [NV] = '{
        {48'h5544_3322_1100, 2'd0, 1'b1, 2'd1},  // R2 exact unicast
        {48'h5544_3322_1100, 2'd3, 1'b1, 2'd1},  // R2 mode irrelevant
        {48'h0A0B_0C0D_0E01, 2'd0, 1'b1, 2'd1},  // R8 exact beats hash
        {48'h0A0B_FFFF_FF01, 2'd0, 1'b1, 2'd2},  // R4 mode0 hash 0x0A0
        {48'hABC1_2300_0001, 2'd0, 1'b1, 2'd2},  // R4 mode0 hash 0xABC
        {48'hABC1_2300_0001, 2'd1, 1'b0, 2'd0},  // R4 mode1 hash 0x578 clear
        {48'hABC1_2300_0001, 2'd2, 1'b0, 2'd0},  // R4 mode2 hash 0xAF0 clear
        {48'hABC1_2300_0001, 2'd3, 1'b1, 2'd2},  // R4 mode3 hash 0xBC1
        {48'hABC1_2300_0000, 2'd0, 1'b0, 2'd0},  // R8 unicast ignores table
        {48'hFFFF_FFFF_FFFF, 2'd2, 1'b1, 2'd3},  // R9 broadcast
        {48'h00A8_0000_0001, 2'd3, 1'b1, 2'd2},  // R5 hash 0x0A8 from word write
        {48'h00A8_0000_0001, 2'd0, 1'b0, 2'd0},  // R4 mode0 hash 0x00A clear
        {48'h1234_5678_9ABC, 2'd0, 1'b0, 2'd0}   // R10 plain miss
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired (R10 run incomplete) actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", 64'(res_valid), 64'd0);
        chk("R1 res_accept", 64'(res_accept), 64'd0);
        chk("R1 res_path", 64'(res_path), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
        rd(3'd1, 7'd1, "R1 slot word", 32'h0);
        rd(3'd3, 7'd0, "R1 table word", 32'h0);
        look(48'h5544_3322_1100, 2'd0, "R1 empty lookup", 1'b0, 2'd0);

        // Configure slots (R2)
        cmd(3'd0, 7'd0, 32'h3322_1100);
        cmd(3'd0, 7'd1, 32'h8000_5544);
        cmd(3'd0, 7'd2, 32'h0C0D_0E01);
        cmd(3'd0, 7'd3, 32'h8000_0A0B);
        rd(3'd1, 7'd0, "R11 slot low", 32'h3322_1100);
        rd(3'd1, 7'd1, "R11 slot high", 32'h8000_5544);

        // R3 slot 2 valid then invalidated by high-word rewrite
        cmd(3'd0, 7'd4, 32'h7777_8803);
        cmd(3'd0, 7'd5, 32'h8000_6666);
        look(48'h6666_7777_8803, 2'd0, "R3 before", 1'b1, 2'd1);
        cmd(3'd0, 7'd5, 32'h0000_6666);
        look(48'h6666_7777_8803, 2'd0, "R3 after", 1'b0, 2'd0);

        // Table: word write then RMW set into same word (R5 R6)
        cmd(3'd2, 7'd5, 32'h0000_0100);
        wait_ready();
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_wdata = 32'h0A0;
        @(negedge clk);
        // R12: command while busy must be dropped
        cmd_op = 3'd2; cmd_idx = 7'd7; cmd_wdata = 32'hFFFF_FFFF;
        begin
            int busy = 0;
            while (!cmd_ready) begin busy++; @(negedge clk); end
            cmd_valid = 1'b0;
            // ready now high; the held strobe was seen at one edge only if ready
            chk("R6 busy cycles", 64'(busy), 64'd2);
        end
        rd(3'd3, 7'd5, "R6 or keeps bits", 32'h0000_0101);
        cmd(3'd4, 7'd0, 32'hABC);
        cmd(3'd4, 7'd0, 32'hBC1);
        rd(3'd3, 7'd85, "R5 word of 0xABC", 32'h1000_0000);
        rd(3'd3, 7'd94, "R5 word of 0xBC1", 32'h0000_0002);

        // R12 unused opcodes
        cmd(3'd6, 7'd1, 32'h0);
        cmd(3'd7, 7'd85, 32'h0);
        rd(3'd1, 7'd1, "R12 opcode6 no effect", 32'h8000_5544);
        rd(3'd3, 7'd85, "R12 opcode7 no effect", 32'h1000_0000);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            look(v[52:5], v[4:3], $sformatf("vec %0d (R2 R4 R5 R8 R9 R10)", i), v[2], v[1:0]);
        end

        // R10 no result without strobe
        @(negedge clk);
        chk("R10 idle res_valid", 64'(res_valid), 64'd0);

        // R7 clear whole table
        wait_ready();
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_idx = '0; cmd_wdata = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int busy = 0;
            while (!cmd_ready) begin busy++; @(negedge clk); end
            chk("R7 busy cycles", 64'(busy), 64'd128);
        end
        rd(3'd3, 7'd85, "R7 word cleared", 32'h0);
        rd(3'd3, 7'd127, "R7 last word cleared", 32'h0);
        look(48'hABC1_2300_0001, 2'd0, "R7 hash gone", 1'b0, 2'd0);
        look(48'h5544_3322_1100, 2'd0, "R7 slots kept", 1'b1, 2'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule